// File: doc/BRIEF.md
# Boot Region Write Guard

This block sits beside the program and erase engine of a byte-wide nonvolatile array and decides, per target address, whether an operation may alter the addressed byte. A 16 KB boot region is protected at one end of the address space. A build parameter selects the end: the lowest addresses (00000h to 03FFFh) or the highest (FC000h to FFFFFh). A one-way lock flag enables protection. A single-cycle set pulse from the command decoder raises the flag. No command clears it, and only the power-on reset loads it from a parameter.

While the flag is set, programs and erases that target the boot region are refused. Operations outside the region always proceed. A chip erase therefore clears the main array and leaves the boot bytes intact. A high-voltage override level lifts the protection for as long as it is held and leaves the flag untouched. In identification mode, a read of address 00002h reports the flag on data bit 0. A refused program still produces a short busy period, so a host that polls for completion sees a normal-looking cycle.

Top module: `boot_guard`

## Requirements
- R1: With bottom placement (TOP_PLACE=0), an address is inside the boot region exactly when it lies in 00000h..03FFFh.
- R2: With top placement (TOP_PLACE=1), an address is inside the boot region exactly when it lies in FC000h..FFFFFh.
- R3: After reset the lock flag equals LOCK_INIT (default 0). A high lock_set_i sampled at a clock edge sets the flag, and the flag takes effect from the following cycle.
- R4: Once set, the lock flag stays set while rst_ni is high. No input combination clears it.
- R5: wr_allow_o is high exactly when op_valid_i is high, op_kind_i is 0 (program), and the address is outside the region, or the flag is clear, or hv_override_i is high.
- R6: er_allow_o is high exactly when op_valid_i is high, op_kind_i is 1 (erase), and the address is outside the region, or the flag is clear, or hv_override_i is high. While locked without the override, erase is allowed for main-array addresses and refused for region addresses.
- R7: Raising hv_override_i re-enables both program and erase in the region in the same cycle. Dropping it restores the refusal in the same cycle, and the flag is unchanged by either transition.
- R8: status_o equals the lock flag when id_mode_i is high and addr_i is 00002h. In every other case status_o is 0.
- R9: A refused program (op_valid_i high, op_kind_i 0, wr_allow_o low) sampled while busy_o is low drives busy_o high for exactly BUSY_CYC cycles, starting the next cycle. A refused program while busy_o is high does not extend the period.
- R10: With op_valid_i low, both wr_allow_o and er_allow_o are 0 regardless of the other inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| addr_i | input | ADDR_W | Target byte address |
| op_valid_i | input | 1 | An operation request is present this cycle |
| op_kind_i | input | 1 | 0 = byte program, 1 = erase |
| lock_set_i | input | 1 | Set pulse from the lockout command |
| hv_override_i | input | 1 | High-voltage override level |
| id_mode_i | input | 1 | Identification mode is active |
| wr_allow_o | output | 1 | Program of addr_i is permitted |
| er_allow_o | output | 1 | Erase of addr_i is permitted |
| status_o | output | 1 | Lockout status bit (data bit 0 of the ID read) |
| busy_o | output | 1 | Busy period after a refused program |

## Verification
The bench drives both placements side by side against a behavioural model. Several functions can act in the same cycle, and the bench provokes the collisions directly. It drives a lockout pulse in the same cycle as a program to the boot region. That program must still be allowed, because the flag only takes effect on the next cycle. It also raises the override during a refused burst and issues a second refused program while the busy period is still running. Each case is judged by comparing the permission outputs, the status bit and the busy output with the model on every clock. The status bit is also read back after the override is released, which confirms the flag survived.

// File: rtl/boot_guard_pkg.sv
package boot_guard_pkg;
  typedef enum logic {
    OP_PROG  = 1'b0,
    OP_ERASE = 1'b1
  } op_kind_e;
endpackage

// File: rtl/bg_region_decode.sv
module bg_region_decode #(
  parameter int ADDR_W    = 20,
  parameter int REGION_W  = 14,
  parameter bit TOP_PLACE = 1'b0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam int HI_W = ADDR_W - REGION_W;

  logic [HI_W-1:0] upper;
  assign upper = addr_i[ADDR_W-1:REGION_W];

  generate
    if (TOP_PLACE) begin : g_top
      assign hit_o = &upper;
    end else begin : g_bottom
      assign hit_o = ~|upper;
    end
  endgenerate
endmodule

// File: rtl/bg_lock_reg.sv
module bg_lock_reg #(
  parameter bit LOCK_INIT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  output logic lock_o
);
  logic lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lock_q <= LOCK_INIT;
    else if (set_i) lock_q <= 1'b1;
  end

  assign lock_o = lock_q;

  a_r4_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(lock_q));
  a_r3_lock_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> lock_q);
endmodule

// File: rtl/bg_busy_timer.sv
module bg_busy_timer #(
  parameter int BUSY_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (cnt_q == '0 && start_i)   cnt_q <= LOAD;
    else if (cnt_q != '0)              cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  a_r9_busy_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  a_r9_busy_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LOAD);
endmodule

// File: rtl/boot_guard.sv
module boot_guard #(
  parameter int ADDR_W    = 20,
  parameter int REGION_W  = 14,
  parameter bit TOP_PLACE = 1'b0,
  parameter bit LOCK_INIT = 1'b0,
  parameter int BUSY_CYC  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              op_valid_i,
  input  logic              op_kind_i,
  input  logic              lock_set_i,
  input  logic              hv_override_i,
  input  logic              id_mode_i,
  output logic              wr_allow_o,
  output logic              er_allow_o,
  output logic              status_o,
  output logic              busy_o
);
  import boot_guard_pkg::*;

  localparam logic [ADDR_W-1:0] ID_LOCK_ADDR = ADDR_W'(2);

  logic     in_region;
  logic     locked;
  logic     guarded;
  logic     prog_refused;
  op_kind_e kind;

  assign kind = op_kind_e'(op_kind_i);

  bg_region_decode #(
    .ADDR_W   (ADDR_W),
    .REGION_W (REGION_W),
    .TOP_PLACE(TOP_PLACE)
  ) u_region (
    .addr_i(addr_i),
    .hit_o (in_region)
  );

  bg_lock_reg #(
    .LOCK_INIT(LOCK_INIT)
  ) u_lock (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (lock_set_i),
    .lock_o(locked)
  );

  // protection applies only inside the region, while locked, without override
  assign guarded    = in_region && locked && !hv_override_i;
  assign wr_allow_o = op_valid_i && (kind == OP_PROG)  && !guarded;
  assign er_allow_o = op_valid_i && (kind == OP_ERASE) && !guarded;

  assign prog_refused = op_valid_i && (kind == OP_PROG) && !wr_allow_o;

  bg_busy_timer #(
    .BUSY_CYC(BUSY_CYC)
  ) u_busy (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(prog_refused),
    .busy_o (busy_o)
  );

  assign status_o = id_mode_i && (addr_i == ID_LOCK_ADDR) && locked;

  a_r5_region_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && in_region && locked && !hv_override_i) |-> !wr_allow_o && !er_allow_o);
  a_r7_override_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && hv_override_i) |-> (wr_allow_o || er_allow_o));
  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |-> !wr_allow_o && !er_allow_o);
  a_r10_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_allow_o, er_allow_o}));
  a_r8_status_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o |-> (locked && id_mode_i));
endmodule

// File: tb/boot_guard_tb_top.sv
module boot_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY_CYC   = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [19:0] addr = '0;
  logic        op_valid = 1'b0, op_kind = 1'b0, lock_set = 1'b0, hv = 1'b0, idm = 1'b0;
  logic        wr_lo, er_lo, st_lo, bz_lo;
  logic        wr_hi, er_hi, st_hi, bz_hi;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  bit lock_m = 1'b0;
  int busy_lo_m = 0, busy_hi_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_guard #(.TOP_PLACE(1'b0), .BUSY_CYC(BUSY_CYC)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .op_valid_i(op_valid),
    .op_kind_i(op_kind), .lock_set_i(lock_set), .hv_override_i(hv),
    .id_mode_i(idm), .wr_allow_o(wr_lo), .er_allow_o(er_lo),
    .status_o(st_lo), .busy_o(bz_lo));

  boot_guard #(.TOP_PLACE(1'b1), .BUSY_CYC(BUSY_CYC)) dut_hi_i (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .op_valid_i(op_valid),
    .op_kind_i(op_kind), .lock_set_i(lock_set), .hv_override_i(hv),
    .id_mode_i(idm), .wr_allow_o(wr_hi), .er_allow_o(er_hi),
    .status_o(st_hi), .busy_o(bz_hi));

  // R1 / R2 region membership, written from the address ranges
  function automatic bit in_reg(input logic [19:0] a, input bit top);
    if (top) return a >= 20'hFC000;
    return a <= 20'h03FFF;
  endfunction

  function automatic bit exp_wr(input bit top);
    return op_valid && !op_kind && !(in_reg(addr, top) && lock_m && !hv);
  endfunction

  function automatic bit exp_er(input bit top);
    return op_valid && op_kind && !(in_reg(addr, top) && lock_m && !hv);
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t addr=%h: actual=%b expected=%b", tag, $time, addr, act, exp);
    end
  endtask

  task automatic compare_all();
    bit st_e;
    st_e = idm && (addr == 20'h00002) && lock_m;
    chk("R1 R5 R10 wr bottom", wr_lo, exp_wr(1'b0));
    chk("R6 R7 R10 er bottom", er_lo, exp_er(1'b0));
    chk("R2 R5 R7 wr top", wr_hi, exp_wr(1'b1));
    chk("R2 R6 er top", er_hi, exp_er(1'b1));
    chk("R3 R4 R8 status bottom", st_lo, st_e);
    chk("R8 status top", st_hi, st_e);
    chk("R9 busy bottom", bz_lo, busy_lo_m != 0);
    chk("R9 busy top", bz_hi, busy_hi_m != 0);
  endtask

  task automatic step(input logic [19:0] a, input bit v, input bit k,
                      input bit ls, input bit h, input bit im);
    bit ref_lo, ref_hi;
    @(negedge clk);
    addr = a; op_valid = v; op_kind = k; lock_set = ls; hv = h; idm = im;
    #1;
    compare_all();
    ref_lo = v && !k && !exp_wr(1'b0);
    ref_hi = v && !k && !exp_wr(1'b1);
    @(posedge clk);
    if (busy_lo_m == 0 && ref_lo) busy_lo_m = BUSY_CYC;
    else if (busy_lo_m != 0) busy_lo_m--;
    if (busy_hi_m == 0 && ref_hi) busy_hi_m = BUSY_CYC;
    else if (busy_hi_m != 0) busy_hi_m--;
    if (ls) lock_m = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(20'h12345, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // reset state, R3
    addr = 20'h00002; idm = 1'b1; op_valid = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R3 reset status", st_lo, 1'b0);
    chk("R9 reset busy", bz_lo, 1'b0);
    @(negedge clk); rst_ni = 1'b1;

    // unlocked: boundaries all allowed, R1 R2 R5 R6
    step(20'h00000, 1, 0, 0, 0, 0);
    step(20'h03FFF, 1, 0, 0, 0, 0);
    step(20'hFC000, 1, 1, 0, 0, 0);
    step(20'h00002, 0, 0, 0, 0, 1);   // R8 status while unlocked
    idle(1);
    // R3 lock pulse in the same cycle as a region program: still allowed
    step(20'h00010, 1, 0, 1, 0, 0);
    step(20'h00010, 1, 0, 0, 0, 0);   // now refused, R5 R9 start
    step(20'h00020, 1, 0, 0, 0, 0);   // refused during busy, R9 no extend
    idle(5);
    // boundaries while locked, R1 R2
    step(20'h03FFF, 1, 0, 0, 0, 0);
    idle(5);
    step(20'h04000, 1, 0, 0, 0, 0);
    step(20'hFBFFF, 1, 0, 0, 0, 0);
    step(20'hFC000, 1, 0, 0, 0, 0);
    idle(5);
    step(20'hFFFFF, 1, 1, 0, 0, 0);   // R6 erase region refused (top)
    step(20'h00000, 1, 1, 0, 0, 0);   // R6 erase refused (bottom)
    step(20'h80000, 1, 1, 0, 0, 0);   // R6 main array erase allowed
    // R7 override on, then off
    step(20'h00100, 1, 0, 0, 1, 0);
    step(20'h00100, 1, 1, 0, 1, 0);
    step(20'hFC100, 1, 0, 0, 1, 0);
    step(20'h00100, 1, 0, 0, 0, 0);
    idle(5);
    // R8 status reads, R4 flag survives override
    step(20'h00002, 0, 0, 0, 0, 1);
    step(20'h00003, 0, 0, 0, 0, 1);
    step(20'h00002, 0, 0, 0, 0, 0);
    step(20'h00002, 1, 1, 1, 1, 1);   // R4 repeated set harmless
    // R10 no request
    step(20'h00000, 0, 1, 0, 0, 0);
    idle(5);

    // mixed stimulus with boundary-biased addresses
    for (int i = 0; i < 400; i++) begin
      logic [19:0] a;
      int sel;
      sel = int'($urandom_range(0, 7));
      case (sel)
        0: a = 20'h03FFF;
        1: a = 20'h04000;
        2: a = 20'hFBFFF;
        3: a = 20'hFC000;
        4: a = 20'h00002;
        default: a = 20'($urandom);
      endcase
      step(a, 1'($urandom), 1'($urandom), 1'b0,
           ($urandom_range(0, 3) == 0), 1'($urandom));
    end

    idle(2);
    finish_run();
  end
endmodule